// File: doc/BRIEF.md
# Programmable AND/OR Logic Matrix

This block is a register-programmed logic unit that turns a 16-bit input word into a 16-bit output word. Each output has two private 16-bit selection masks. The first picks inputs that must all be high. The second picks inputs of which any one being high is enough. The two terms are ORed together. A per-output complement bit can then invert the result. The outputs leave the block from a register.

A plain synchronous register bus configures the block. The bus has a byte address, a write strobe, write data and combinational read data. Through it, software writes and reads back every mask, the complement word, a mode word and a test pattern. It can also read a fixed version word, the synchronized input word and the registered output word. Setting the test-mode bit replaces the synchronized pins with the test pattern, so the programmed logic can be exercised with no external stimulus. A second mode bit drives an indicator lamp.

Live pins pass through a two-flop synchronizer before the logic. This gives a fixed pin-to-output latency. In test mode the pattern feeds the logic directly.

Top module: `logic_matrix`

## Requirements
- R1: Output n has an AND term. The term is 1 only when that output's AND mask (byte address 0x4C + 2n) is nonzero and every input whose mask bit is set is high. An all-zero AND mask contributes 0.
- R2: Output n has an OR term. The term is 1 when any input selected by that output's OR mask (byte address 0x6C + 2n) is high.
- R3: Output n equals (AND term OR OR term) XOR bit n of the complement word at address 0x4A.
- R4: Every AND mask, every OR mask and the complement word read back the last value written to their addresses.
- R5: The mode word is at address 0x1E. Bit 6 selects test mode and bit 7 turns on `lamp_red`. Bits 0 to 5 and 8 to 15 always read 0.
- R6: The test pattern is at address 0x8C and is readable. In test mode it replaces the inputs with no synchronizer delay, so a pattern write is visible on `out_q` after the next clock edge.
- R7: In normal mode, a change on `pins_in` reaches `out_q` on the third rising clock edge after the change. It does not appear on the first or second edge.
- R8: Address 0x48 reads 0x0001. Writes to it have no effect.
- R9: After reset, every writable register is 0x0000, `out_q` is 0 and `lamp_red` is 0.
- R10: Address 0x8E reads the synchronized input word. Address 0x90 reads the current `out_q`.
- R11: Odd addresses and unmapped even addresses read 0x0000. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | 16 | Live input word, asynchronous to clk |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| out_q | output | 16 | Registered output word |
| lamp_red | output | 1 | Indicator lamp, mode bit 7 |

## Verification
The AND path uses a two-input mask with four patterns: both selected high, only one high, all ones and all zeros. These separate a true AND from an OR and from "any bit set". The OR path uses patterns that light only one selected input, and a pattern that sets every unselected input while leaving the selected ones low, which exposes masking errors. A mixed output, with both masks programmed and complemented outputs that have empty masks, shows that the terms combine by OR before the inversion. In test mode the live pins carry a conflicting word, so outputs computed from the wrong source are caught.

// File: rtl/plm_pkg.sv
package plm_pkg;
   // register byte addresses (map is fixed; decode depends on it)
   localparam int unsigned PLM_A_MODE    = 'h1E;
   localparam int unsigned PLM_A_VERSION = 'h48;
   localparam int unsigned PLM_A_INVERT  = 'h4A;
   localparam int unsigned PLM_A_AND0    = 'h4C;
   localparam int unsigned PLM_A_OR0     = 'h6C;
   localparam int unsigned PLM_A_TEST    = 'h8C;
   localparam int unsigned PLM_A_INWORD  = 'h8E;
   localparam int unsigned PLM_A_OUTWORD = 'h90;
   localparam int unsigned PLM_A_STRIDE  = 2;
   // mode word bit positions
   localparam int unsigned PLM_MODE_TEST_BIT = 6;
   localparam int unsigned PLM_MODE_LAMP_BIT = 7;
   localparam int unsigned PLM_VERSION_WORD  = 'h0001;
endpackage

// File: rtl/plm_sync.sv
module plm_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= d_async;
               for (int s = 1; s < STAGES; s++) begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign q_sync = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/plm_regs.sv
module plm_regs
   import plm_pkg::*;
#(
   parameter int unsigned N_IN   = 16,
   parameter int unsigned N_OUT  = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_wr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   input  logic [N_IN-1:0]             in_word,
   input  logic [N_OUT-1:0]            out_word,
   output logic [N_OUT-1:0][N_IN-1:0]  and_mask,
   output logic [N_OUT-1:0][N_IN-1:0]  or_mask,
   output logic [N_OUT-1:0]            invert,
   output logic [N_IN-1:0]             test_pat,
   output logic                        test_en,
   output logic                        lamp_on
);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(PLM_A_MODE);
   localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(PLM_A_VERSION);
   localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(PLM_A_INVERT);
   localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(PLM_A_TEST);
   localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(PLM_A_INWORD);
   localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(PLM_A_OUTWORD);

   // per-output mask registers
   generate
      for (genvar g = 0; g < N_OUT; g++) begin : g_mask
         localparam logic [ADDR_W-1:0] A_AND_G = ADDR_W'(PLM_A_AND0 + PLM_A_STRIDE * g);
         localparam logic [ADDR_W-1:0] A_OR_G  = ADDR_W'(PLM_A_OR0 + PLM_A_STRIDE * g);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               and_mask[g] <= '0;
               or_mask[g]  <= '0;
            end else if (bus_wr) begin
               if (bus_addr == A_AND_G) and_mask[g] <= bus_wdata[N_IN-1:0];
               if (bus_addr == A_OR_G)  or_mask[g]  <= bus_wdata[N_IN-1:0];
            end
         end
      end
   endgenerate

   // control registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         invert   <= '0;
         test_pat <= '0;
         test_en  <= 1'b0;
         lamp_on  <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == A_INV)  invert   <= bus_wdata[N_OUT-1:0];
         if (bus_addr == A_TEST) test_pat <= bus_wdata[N_IN-1:0];
         if (bus_addr == A_MODE) begin
            test_en <= bus_wdata[PLM_MODE_TEST_BIT];
            lamp_on <= bus_wdata[PLM_MODE_LAMP_BIT];
         end
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_MODE) begin
         bus_rdata[PLM_MODE_TEST_BIT] = test_en;
         bus_rdata[PLM_MODE_LAMP_BIT] = lamp_on;
      end
      if (bus_addr == A_VER)  bus_rdata = DATA_W'(PLM_VERSION_WORD);
      if (bus_addr == A_INV)  bus_rdata = DATA_W'(invert);
      if (bus_addr == A_TEST) bus_rdata = DATA_W'(test_pat);
      if (bus_addr == A_IN)   bus_rdata = DATA_W'(in_word);
      if (bus_addr == A_OUT)  bus_rdata = DATA_W'(out_word);
      for (int i = 0; i < N_OUT; i++) begin
         if (bus_addr == ADDR_W'(PLM_A_AND0 + PLM_A_STRIDE * i)) bus_rdata = DATA_W'(and_mask[i]);
         if (bus_addr == ADDR_W'(PLM_A_OR0 + PLM_A_STRIDE * i))  bus_rdata = DATA_W'(or_mask[i]);
      end
   end
endmodule

// File: rtl/plm_cell.sv
module plm_cell #(
   parameter int unsigned N_IN = 16
) (
   input  logic [N_IN-1:0] src,
   input  logic [N_IN-1:0] and_sel,
   input  logic [N_IN-1:0] or_sel,
   input  logic            inv,
   output logic            y
);
   logic and_term;
   logic or_term;
   always_comb begin
      // unselected inputs are forced high so they never veto the AND
      and_term = (|and_sel) & (&(src | ~and_sel));
      or_term  = |(src & or_sel);
      y        = (and_term | or_term) ^ inv;
   end
endmodule

// File: rtl/logic_matrix.sv
module logic_matrix
   import plm_pkg::*;
#(
   parameter int unsigned N_IN        = 16,
   parameter int unsigned N_OUT       = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   pins_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_OUT-1:0]  out_q,
   output logic              lamp_red
);
   localparam int unsigned MAX_ADDR = PLM_A_OUTWORD;

   generate
      if (N_IN == 0 || N_IN > DATA_W) begin : g_chk_in
         $error("logic_matrix: N_IN must be 1..DATA_W");
      end
      if (N_OUT == 0 || N_OUT > DATA_W) begin : g_chk_out
         $error("logic_matrix: N_OUT must be 1..DATA_W");
      end
      if (DATA_W <= PLM_MODE_LAMP_BIT) begin : g_chk_data
         $error("logic_matrix: DATA_W too narrow for mode bits");
      end
      if ((1 << ADDR_W) <= MAX_ADDR) begin : g_chk_addr
         $error("logic_matrix: ADDR_W cannot reach the register map");
      end
   endgenerate

   logic [N_IN-1:0]            sync_word;
   logic [N_IN-1:0]            src_word;
   logic [N_OUT-1:0][N_IN-1:0] and_mask;
   logic [N_OUT-1:0][N_IN-1:0] or_mask;
   logic [N_OUT-1:0]           invert;
   logic [N_IN-1:0]            test_pat;
   logic                       test_en;
   logic [N_OUT-1:0]           next_out;

   plm_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_in),
      .q_sync  (sync_word)
   );

   plm_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .in_word   (sync_word),
      .out_word  (out_q),
      .and_mask  (and_mask),
      .or_mask   (or_mask),
      .invert    (invert),
      .test_pat  (test_pat),
      .test_en   (test_en),
      .lamp_on   (lamp_red)
   );

   assign src_word = test_en ? test_pat : sync_word;

   generate
      for (genvar g = 0; g < N_OUT; g++) begin : g_cell
         plm_cell #(.N_IN(N_IN)) u_cell (
            .src     (src_word),
            .and_sel (and_mask[g]),
            .or_sel  (or_mask[g]),
            .inv     (invert[g]),
            .y       (next_out[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= next_out;
   end
endmodule

// File: rtl/plm_checker.sv
module plm_checker
   import plm_pkg::*;
#(
   parameter int unsigned N_OUT  = 16,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [N_OUT-1:0]  out_q,
   input logic              lamp_red
);
   a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_q == '0 && !lamp_red));

   a_r8_version: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(PLM_A_VERSION)) |-> (bus_rdata == DATA_W'(PLM_VERSION_WORD)));

   a_r11_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr[0] |-> (bus_rdata == '0));

   a_r10_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(PLM_A_OUTWORD)) |-> (bus_rdata == DATA_W'(out_q)));

   a_r5_mode_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(PLM_A_MODE)) |->
         ((bus_rdata & ~(DATA_W'(1) << PLM_MODE_TEST_BIT) & ~(DATA_W'(1) << PLM_MODE_LAMP_BIT)) == '0));

   a_r5_lamp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(PLM_A_MODE)) |=> (lamp_red == $past(bus_wdata[PLM_MODE_LAMP_BIT])));

   a_r5_lamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !(bus_wr && bus_addr == ADDR_W'(PLM_A_MODE))) |=> $stable(lamp_red));
endmodule

bind logic_matrix plm_checker #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .out_q     (out_q),
   .lamp_red  (lamp_red)
);

// File: tb/logic_matrix_bench.sv
module logic_matrix_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pins_in = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] out_q;
   logic        lamp_red;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] m_and [16];
   logic [15:0] m_or  [16];
   logic [15:0] m_inv;
   logic [15:0] m_test;
   bit          m_tmode;

   always #10 clk = ~clk;

   logic_matrix u_logic_matrix (
      .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .out_q(out_q), .lamp_red(lamp_red)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [15:0] model(input logic [15:0] src);
      logic [15:0] r;
      for (int n = 0; n < 16; n++) begin
         logic a_t, o_t;
         a_t = (m_and[n] != 0) && ((src & m_and[n]) == m_and[n]);
         o_t = (src & m_or[n]) != 0;
         r[n] = (a_t | o_t) ^ m_inv[n];
      end
      return r;
   endfunction

   task automatic set_and(input int n, input logic [15:0] v);
      wr(8'(8'h4C + 2 * n), v); m_and[n] = v;
   endtask
   task automatic set_or(input int n, input logic [15:0] v);
      wr(8'(8'h6C + 2 * n), v); m_or[n] = v;
   endtask
   task automatic set_inv(input logic [15:0] v);
      wr(8'h4A, v); m_inv = v;
   endtask

   task automatic clear_all();
      for (int n = 0; n < 16; n++) begin
         set_and(n, 16'h0); set_or(n, 16'h0);
      end
      set_inv(16'h0);
      wr(8'h1E, 16'h0); m_tmode = 0;
   endtask

   task automatic apply_pins(input logic [15:0] p, input string req);
      @(negedge clk);
      pins_in = p;
      repeat (4) @(negedge clk);
      chk(req, out_q, model(p));
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R9 out_q", out_q, 16'h0);
      chk("R9 lamp", {15'h0, lamp_red}, 16'h0);
      rd(8'h1E, d); chk("R9 mode", d, 16'h0);
      rd(8'h4C, d); chk("R9 and0", d, 16'h0);
      rd(8'h8A, d); chk("R9 or15", d, 16'h0);
      rd(8'h4A, d); chk("R9 invert", d, 16'h0);
      rd(8'h8C, d); chk("R9 test", d, 16'h0);
   endtask

   task automatic t_and();
      set_and(0, 16'h0005);
      apply_pins(16'h0005, "R1 both selected");
      chk("R1 out0 high", {15'h0, out_q[0]}, 16'h1);
      apply_pins(16'h0001, "R1 one selected");
      chk("R1 out0 low", {15'h0, out_q[0]}, 16'h0);
      apply_pins(16'hFFFF, "R1 all ones");
      apply_pins(16'h0000, "R1 all zeros");
      chk("R1 empty mask out1", {15'h0, out_q[1]}, 16'h0);
   endtask

   task automatic t_or();
      set_or(1, 16'h0024);
      apply_pins(16'h0004, "R2 bit2");
      chk("R2 out1 high", {15'h0, out_q[1]}, 16'h1);
      apply_pins(16'h0020, "R2 bit5");
      apply_pins(16'hFFDB, "R2 unselected only");
      chk("R2 out1 low", {15'h0, out_q[1]}, 16'h0);
   endtask

   task automatic t_combo();
      set_and(3, 16'h000F); set_or(3, 16'h0100);
      set_inv(16'h0005);
      apply_pins(16'h000F, "R3 and term");
      apply_pins(16'h0100, "R3 or term");
      apply_pins(16'h0007, "R3 neither");
      chk("R3 inverted empty out2", {15'h0, out_q[2]}, 16'h1);
      chk("R3 out3 low", {15'h0, out_q[3]}, 16'h0);
   endtask

   task automatic t_map();
      logic [15:0] d;
      for (int n = 0; n < 16; n++) begin
         set_and(n, 16'(16'hA100 + n)); set_or(n, 16'(16'h5200 + 3 * n));
      end
      for (int n = 0; n < 16; n++) begin
         rd(8'(8'h4C + 2 * n), d); chk("R4 and readback", d, 16'(16'hA100 + n));
         rd(8'(8'h6C + 2 * n), d); chk("R4 or readback", d, 16'(16'h5200 + 3 * n));
      end
      rd(8'h4A, d); chk("R4 invert readback", d, m_inv);
      clear_all();
   endtask

   task automatic t_latency();
      set_and(0, 16'h0001);
      apply_pins(16'h0000, "R7 setup");
      @(negedge clk); pins_in = 16'h0001;
      @(posedge clk); @(negedge clk);
      chk("R7 edge1", {15'h0, out_q[0]}, 16'h0);
      @(posedge clk); @(negedge clk);
      chk("R7 edge2", {15'h0, out_q[0]}, 16'h0);
      @(posedge clk); @(negedge clk);
      chk("R7 edge3", {15'h0, out_q[0]}, 16'h1);
      clear_all();
   endtask

   task automatic t_test_mode();
      logic [15:0] d;
      set_and(0, 16'h0005);
      @(negedge clk); pins_in = 16'h0000;
      wr(8'h1E, 16'h0040); m_tmode = 1;
      rd(8'h1E, d); chk("R5 mode test bit", d, 16'h0040);
      // wr returns at the negedge after the capturing edge
      @(negedge clk); bus_addr = 8'h8C; bus_wdata = 16'h0005; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk); bus_wr = 1'b0; m_test = 16'h0005;
      @(posedge clk); @(negedge clk);
      chk("R6 test pattern one edge", out_q, model(m_test));
      rd(8'h8C, d); chk("R6 test readback", d, 16'h0005);
      @(negedge clk); pins_in = 16'hFFFF;
      repeat (4) @(negedge clk);
      chk("R6 pins ignored", out_q, model(m_test));
      wr(8'h1E, 16'h00BF);
      rd(8'h1E, d); chk("R5 reserved bits zero", d, 16'h0080);
      chk("R5 lamp on", {15'h0, lamp_red}, 16'h1);
      repeat (4) @(negedge clk);
      chk("R5 normal mode uses pins", out_q, model(16'hFFFF));
      clear_all();
      chk("R5 lamp off", {15'h0, lamp_red}, 16'h0);
   endtask

   task automatic t_version_unmapped();
      logic [15:0] d;
      wr(8'h48, 16'h1234);
      rd(8'h48, d); chk("R8 version", d, 16'h0001);
      set_and(0, 16'h00F0);
      wr(8'h4D, 16'hFFFF);
      wr(8'h00, 16'hFFFF);
      wr(8'h92, 16'hFFFF);
      rd(8'h4C, d); chk("R11 and0 untouched", d, 16'h00F0);
      rd(8'h4D, d); chk("R11 odd read", d, 16'h0);
      rd(8'h92, d); chk("R11 unmapped read", d, 16'h0);
      rd(8'h1E, d); chk("R11 mode untouched", d, 16'h0);
      clear_all();
   endtask

   task automatic t_readback();
      logic [15:0] d;
      set_or(6, 16'h8000); set_inv(16'h0010);
      apply_pins(16'h8C31, "R10 setup");
      rd(8'h8E, d); chk("R10 input word", d, 16'h8C31);
      rd(8'h90, d); chk("R10 output word", d, model(16'h8C31));
      clear_all();
   endtask

   initial begin
      for (int n = 0; n < 16; n++) begin m_and[n] = 0; m_or[n] = 0; end
      m_inv = 0; m_test = 0; m_tmode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_and();
      t_or();
      t_combo();
      clear_all();
      t_map();
      t_latency();
      t_test_mode();
      t_version_unmapped();
      t_readback();
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule